// File: doc/BRIEF.md
# Separable Pyramid Convolution Sequencer

This block sequences an array of five-tap multiply-accumulate elements through a separable Gaussian blur of every level of an image pyramid. For each level it first fetches that level's kernel weights. It then sweeps a horizontal pass over the frame and after that a vertical pass. On each array cycle the whole array handles one group of pixels, one pixel per element. The block keeps three nested counters: the pyramid level on the outside, the pass (horizontal or vertical) in the middle, and the group index within the pass on the inside.

All traffic goes to an external memory port with a request/valid pair. While a read is requested, the memory raises `rd_valid` to say that this cycle's data is present. Any cycle in a pass without `rd_valid` is a stall, and nothing advances. Pass results go to the half of a ping-pong region that the pass does not read from, so the vertical pass reads what the horizontal pass wrote. After each level, the width and the height both halve for the next level.

The number of groups in a pass is (width >> level) × (height >> level) divided by the element count, rounded up. The array width, the frame size and the level count are parameters. The default array of 640 elements divides both 1280 and 1920.

Top module: `sc_conv_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `rd_req`, `wr_en`, `done`, `phase`, `level` and `cyc_cnt` are all zero.
- R2: A `start` high in the idle state moves the block to a weight fetch on the next cycle. The weight fetch drives `rd_req`=1, `rd_kind`=1 and `rd_addr` = the level index zero-extended, and holds until `rd_valid`. A `start` seen in any other state is ignored.
- R3: During a pass, `rd_kind`=0 and `rd_addr` = {level, phase, cyc_cnt}: level in the top LVL_W bits, then one phase bit, then CYC_W bits of group index.
- R4: In a pass cycle with `rd_valid` high, `wr_en` is high in that same cycle and `wr_addr` = {level, ~phase, cyc_cnt}. Results therefore go to the other ping-pong half from the one being read.
- R5: A pass cycle with `rd_valid` low is a stall. There is no write, and `cyc_cnt`, `phase` and `level` keep their values.
- R6: A pass at level L has ceil((FRAME_W>>L)·(FRAME_H>>L)/N_ELEM) groups. After the last group of the horizontal pass, `phase` goes to 1 and `cyc_cnt` to 0. After the last group of the vertical pass, the block spends one cycle with no request.
- R7: After that one no-request cycle, `level` increments and a new weight fetch begins. After the last level, `done` pulses for exactly one cycle and the block returns to idle.
- R8: A full run issues exactly 2·Σ groups(L) writes, summed over all levels.
- R9: `phase` is 0 in the horizontal pass, 1 in the vertical pass, and 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a full pyramid run (acted on only when idle) |
| rd_valid | input | 1 | Memory has the requested read data this cycle |
| rd_req | output | 1 | Read request |
| rd_kind | output | 1 | 1 = weight fetch, 0 = pixel group fetch |
| rd_addr | output | ADDR_W | Read address |
| wr_en | output | 1 | Write updated pixel group |
| wr_addr | output | ADDR_W | Write address |
| phase | output | 1 | 0 horizontal, 1 vertical |
| level | output | LVL_W | Current pyramid level |
| cyc_cnt | output | CYC_W | Group index in the current pass |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can land in the same cycle: the final write-back of a pass and the move to the next pass or level. When they coincide, the write must still carry the old phase and group index, and the following cycle's read must already carry the new ones. The bench provokes this collision directly: it stalls `rd_valid` on the last group of a pass several times before releasing it. Random stall patterns also produce it. Each cycle the bench compares both addresses with its own model of the counters. The second collision is a `start` that arrives in the same cycle as `done`. The bench holds `start` high through a whole run to create it, and checks that no second run begins.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WLOAD,
        ST_HPASS,
        ST_VPASS,
        ST_STEP,
        ST_FIN
    } st_e;

    // Pixel groups handled by one pass at a pyramid level (ceiling division).
    function automatic int unsigned grp_count(int unsigned w, int unsigned h,
                                              int unsigned n, int unsigned lvl);
        int unsigned pix;
        pix = (w >> lvl) * (h >> lvl);
        return (pix + n - 1) / n;
    endfunction

endpackage

// File: rtl/sc_grp_table.sv
module sc_grp_table
    import sc_pkg::*;
#(
    parameter int N_ELEM  = 640,
    parameter int FRAME_W = 1280,
    parameter int FRAME_H = 720,
    parameter int LEVELS  = 3,
    parameter int LVL_W   = 2,
    parameter int CYC_W   = 11
) (
    input  logic [LVL_W-1:0] lvl,
    output logic [CYC_W-1:0] last_idx
);

    logic [CYC_W-1:0] last_tab [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign last_tab[g] = CYC_W'(grp_count(FRAME_W, FRAME_H, N_ELEM, g) - 1);
    end

    assign last_idx = last_tab[lvl];

endmodule

// File: rtl/sc_addr_gen.sv
module sc_addr_gen #(
    parameter int LVL_W  = 2,
    parameter int CYC_W  = 11,
    parameter int ADDR_W = LVL_W + 1 + CYC_W
) (
    input  logic              wt_fetch,
    input  logic [LVL_W-1:0]  lvl,
    input  logic              ph,
    input  logic [CYC_W-1:0]  cyc,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr
);

    always_comb begin
        if (wt_fetch) begin
            rd_addr = ADDR_W'(lvl);
        end else begin
            rd_addr = {lvl, ph, cyc};
        end
        wr_addr = {lvl, ~ph, cyc};
    end

endmodule

// File: rtl/sc_conv_seq.sv
module sc_conv_seq
    import sc_pkg::*;
#(
    parameter  int N_ELEM  = 640,
    parameter  int FRAME_W = 1280,
    parameter  int FRAME_H = 720,
    parameter  int LEVELS  = 3,
    localparam int MAX_GRP = int'(grp_count(FRAME_W, FRAME_H, N_ELEM, 0)),
    localparam int CYC_W   = (MAX_GRP > 1) ? $clog2(MAX_GRP) : 1,
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int ADDR_W  = LVL_W + 1 + CYC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_valid,
    output logic              rd_req,
    output logic              rd_kind,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              phase,
    output logic [LVL_W-1:0]  level,
    output logic [CYC_W-1:0]  cyc_cnt,
    output logic              done
);

    typedef struct packed {
        st_e              st;
        logic [LVL_W-1:0] lvl;
        logic [CYC_W-1:0] cyc;
    } ctl_t;

    ctl_t             r_d, r_q;
    logic [CYC_W-1:0] last_idx;
    logic             in_pass;

    sc_grp_table #(
        .N_ELEM (N_ELEM),
        .FRAME_W(FRAME_W),
        .FRAME_H(FRAME_H),
        .LEVELS (LEVELS),
        .LVL_W  (LVL_W),
        .CYC_W  (CYC_W)
    ) u_tab (
        .lvl     (r_q.lvl),
        .last_idx(last_idx)
    );

    sc_addr_gen #(
        .LVL_W (LVL_W),
        .CYC_W (CYC_W),
        .ADDR_W(ADDR_W)
    ) u_addr (
        .wt_fetch(r_q.st == ST_WLOAD),
        .lvl     (r_q.lvl),
        .ph      (r_q.st == ST_VPASS),
        .cyc     (r_q.cyc),
        .rd_addr (rd_addr),
        .wr_addr (wr_addr)
    );

    assign in_pass = (r_q.st == ST_HPASS) || (r_q.st == ST_VPASS);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st  = ST_WLOAD;
                    r_d.lvl = '0;
                    r_d.cyc = '0;
                end
            end
            ST_WLOAD: begin
                if (rd_valid) begin
                    r_d.st = ST_HPASS;
                end
            end
            ST_HPASS, ST_VPASS: begin
                if (rd_valid) begin
                    if (r_q.cyc == last_idx) begin
                        r_d.cyc = '0;
                        r_d.st  = (r_q.st == ST_HPASS) ? ST_VPASS : ST_STEP;
                    end else begin
                        r_d.cyc = r_q.cyc + 1'b1;
                    end
                end
            end
            ST_STEP: begin
                if (r_q.lvl == LVL_W'(LEVELS - 1)) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.lvl = r_q.lvl + 1'b1;
                    r_d.st  = ST_WLOAD;
                end
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, lvl: '0, cyc: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req  = in_pass || (r_q.st == ST_WLOAD);
    assign rd_kind = (r_q.st == ST_WLOAD);
    assign wr_en   = in_pass && rd_valid;
    assign phase   = (r_q.st == ST_VPASS);
    assign level   = r_q.lvl;
    assign cyc_cnt = r_q.cyc;
    assign done    = (r_q.st == ST_FIN);

endmodule

// File: rtl/sc_conv_chk.sv
module sc_conv_chk #(
    parameter int LEVELS = 3,
    parameter int LVL_W  = 2,
    parameter int CYC_W  = 11,
    parameter int ADDR_W = LVL_W + 1 + CYC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic              rd_req,
    input logic              rd_kind,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              phase,
    input logic [LVL_W-1:0]  level,
    input logic [CYC_W-1:0]  cyc_cnt,
    input logic              done
);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_kind && !rd_valid) |=> ($stable(cyc_cnt) && $stable(phase) && $stable(level)));

    // R4
    wr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rd_valid && rd_req && !rd_kind));

    // R4
    pingpong_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_addr[CYC_W] != rd_addr[CYC_W]) &&
                   (wr_addr[CYC_W-1:0] == rd_addr[CYC_W-1:0])));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    phase_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase) |-> (cyc_cnt == '0 && rd_req && !rd_kind));

    // R6
    phase_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase) |-> !rd_req);

    // R7
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) < LEVELS);

endmodule

bind sc_conv_seq sc_conv_chk #(
    .LEVELS(LEVELS),
    .LVL_W (LVL_W),
    .CYC_W (CYC_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_valid(rd_valid),
    .rd_req  (rd_req),
    .rd_kind (rd_kind),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .phase   (phase),
    .level   (level),
    .cyc_cnt (cyc_cnt),
    .done    (done)
);

// File: tb/sc_conv_seq_bench.sv
module sc_conv_seq_bench;

    localparam int N  = 4;
    localparam int W  = 16;
    localparam int H  = 8;
    localparam int L  = 3;
    localparam int CW = 5;
    localparam int LW = 2;
    localparam int AW = LW + 1 + CW;
    localparam time CLK_NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rd_valid = 1'b0;
    logic          rd_req, rd_kind, wr_en, phase, done;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [LW-1:0] level;
    logic [CW-1:0] cyc_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_NS / 2) clk = ~clk;

    sc_conv_seq #(.N_ELEM(N), .FRAME_W(W), .FRAME_H(H), .LEVELS(L)) u_sc_conv_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_valid(rd_valid),
        .rd_req(rd_req), .rd_kind(rd_kind), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .phase(phase), .level(level),
        .cyc_cnt(cyc_cnt), .done(done)
    );

    // model state: 0 idle, 1 weight fetch, 2 pass, 3 level step, 4 finish
    int            m_st = 0;
    logic [LW-1:0] m_lvl = '0;
    logic [CW-1:0] m_cyc = '0;
    logic          m_ph = 1'b0;
    int            wr_seen, done_seen;

    function automatic int groups(int lv);
        return (((W >> lv) * (H >> lv)) + N - 1) / N;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_outputs();
        logic [AW-1:0] e_rd, e_wr;
        e_rd = (m_st == 1) ? AW'(m_lvl) : {m_lvl, m_ph, m_cyc};
        e_wr = {m_lvl, ~m_ph, m_cyc};
        chk("R2 rd_req", 32'(rd_req), 32'(m_st == 1 || m_st == 2));
        if (m_st == 1) begin
            chk("R2 rd_kind", 32'(rd_kind), 32'd1);
            chk("R2 weight addr", 32'(rd_addr), 32'(e_rd));
        end
        if (m_st == 2) begin
            chk("R3 rd_kind", 32'(rd_kind), 32'd0);
            chk("R3 pixel addr", 32'(rd_addr), 32'(e_rd));
        end
        chk("R4 wr_en", 32'(wr_en), 32'(m_st == 2 && rd_valid));
        if (m_st == 2 && rd_valid) chk("R4 wr_addr", 32'(wr_addr), 32'(e_wr));
        chk("R5 cyc_cnt", 32'(cyc_cnt), 32'(m_cyc));
        chk("R9 phase", 32'(phase), 32'(m_st == 2 && m_ph));
        chk("R7 level", 32'(level), 32'(m_lvl));
        chk("R7 done", 32'(done), 32'(m_st == 4));
    endtask

    task automatic model_step(logic s, logic v);
        case (m_st)
            0: if (s) begin m_st = 1; m_lvl = '0; m_cyc = '0; end
            1: if (v) begin m_st = 2; m_ph = 1'b0; end
            2: if (v) begin
                wr_seen++;
                if (int'(m_cyc) == groups(int'(m_lvl)) - 1) begin
                    m_cyc = '0;
                    if (!m_ph) m_ph = 1'b1;
                    else begin m_ph = 1'b0; m_st = 3; end
                end else begin
                    m_cyc = m_cyc + 1'b1;
                end
            end
            3: if (int'(m_lvl) == L - 1) m_st = 4;
               else begin m_lvl = m_lvl + 1'b1; m_st = 1; end
            4: m_st = 0;
            default: m_st = 0;
        endcase
    endtask

    // vmode: 0 always valid, 1 random 50%, 2 random 20%, 3 stall on every last group
    // smode: 0 single pulse, 1 random junk starts, 2 start held high throughout
    task automatic run(int vmode, int smode);
        int guard = 0;
        int hold = 0;
        int exp_wr = 0;
        for (int lv = 0; lv < L; lv++) exp_wr += 2 * groups(lv);
        wr_seen = 0;
        done_seen = 0;
        @(negedge clk);
        start = 1'b1;
        rd_valid = 1'b0;
        #1 compare_outputs();
        @(posedge clk);
        model_step(start, rd_valid);
        while (m_st != 0 && guard < 5000) begin
            guard++;
            @(negedge clk);
            case (vmode)
                0: rd_valid = 1'b1;
                1: rd_valid = ($urandom % 2) == 0;
                2: rd_valid = ($urandom % 5) == 0;
                default: begin
                    if (m_st == 2 && int'(m_cyc) == groups(int'(m_lvl)) - 1 && hold < 3) begin
                        rd_valid = 1'b0;
                        hold++;
                    end else begin
                        rd_valid = 1'b1;
                        hold = 0;
                    end
                end
            endcase
            case (smode)
                0: start = 1'b0;
                1: start = ($urandom % 3) == 0;
                default: start = 1'b1;
            endcase
            #1 compare_outputs();
            if (done) done_seen++;
            @(posedge clk);
            model_step(start, rd_valid);
        end
        if (guard >= 5000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 run did not finish actual=%0d expected<5000", guard);
        end
        @(negedge clk);
        start = 1'b0;
        rd_valid = 1'b1;
        #1 compare_outputs();
        chk("R8 write count", 32'(wr_seen), 32'(exp_wr));
        chk("R7 done pulses", 32'(done_seen), 32'd1);
        @(posedge clk);
        model_step(start, rd_valid);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 rd_req", 32'(rd_req), 32'd0);
        chk("R1 wr_en", 32'(wr_en), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 level", 32'(level), 32'd0);
        chk("R1 cyc_cnt", 32'(cyc_cnt), 32'd0);
        chk("R1 phase", 32'(phase), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_outputs();
        // R6 group counts per level come from groups(); each run checks them cycle by cycle
        run(0, 0);
        run(3, 0);
        run(1, 1);
        run(2, 1);
        run(1, 2);
        run(3, 2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule